// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a small set of active-low external interrupt lines. It turns their activity into one interrupt request for a processor core, together with the address of the vector slot that the core should fetch. Each line passes through a two-stage synchroniser. Software then picks one of two trigger modes for each line: a falling transition, which also catches a short low pulse, or a held low level, which suits several open-drain sources sharing one wire. A detected trigger sets two things for that source. One is an internal capture bit, which the core's acknowledge consumes. The other is a flag that software can see and that only a write of one clears.

The request is raised when at least one source has its flag set and its enable bit set, and the core's interrupt mask input is low. Sources have a fixed priority, with index 0 the highest. The vector output is the address of the first byte of the two-byte vector that belongs to the winning source. The capture bit is cleared on acknowledge while the flag stays set, so exactly one further pulse that arrives during service is kept. That pulse is presented again once software clears the flag.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable register, the sense register and the flag register all read 0, and `irq_req` is low.
- R2: In edge mode (sense bit 0), a high-to-low change on `line_n[i]` sets flag bit i. The flag is visible on the third rising clock edge after the line falls, and not earlier. A line that stays low does not set the flag again once the flag has been cleared.
- R3: In level mode (sense bit 1), the flag keeps being set for as long as the line is low, so a write-one-to-clear has no effect while the line stays low. The flag can be cleared once the line is high again.
- R4: `irq_req` is high exactly when some source i has both flag bit i and enable bit i set and `imask` is low.
- R5: Among the sources that are flagged and enabled, index 0 wins over 1, and 1 wins over 2. `vec_addr` is VEC_TOP - i*(i+1), which gives 16'h3FFA, 16'h3FF8 and 16'h3FF4 for sources 0, 1 and 2 with the defaults.
- R6: Writing register address 2 clears each flag bit written as 1, provided that source has no unconsumed capture. Bits written as 0 leave their flags unchanged.
- R7: A one-cycle `ack` clears only the capture bit of the current winning source. The flag of that source stays set.
- R8: After `ack`, one further trigger, and only one, is kept. However many pulses arrive, the first write-one-to-clear leaves the flag set, and a second `ack` followed by a write-one-to-clear clears it.
- R9: Register map: address 0 is enable, address 1 is sense (1 = level), address 2 is flags, and address 3 reads 0 and ignores writes. Source i sits in bit i.
- R10: A trigger in the same cycle as a write-one-to-clear of the same bit leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_n | input | NSRC | Asynchronous active-low interrupt lines |
| imask | input | 1 | Core interrupt mask; high blocks the request |
| ack | input | 1 | One-cycle acknowledge of the current winner |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Combinational read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | 16 | First byte address of the winning source's vector |

## Verification
The bench uses the defaults: three sources and a vector top of 16'h3FFA. With these values all three priority levels and all three distinct vector slots can be observed at the ports. The stimulus places a trigger in the exact cycle of a clear write. It also stacks several pulses inside one service window to show that only one is kept. A level-sensed line is held low across a clear to show the flag stays set.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_SENSE  = 2'd1,
    REG_FLAGS  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // Vector slot of source idx: slots step down by a triangular spacing.
  function automatic logic [15:0] vec_slot(input logic [15:0] top, input int idx);
    return top - 16'(idx * (idx + 1));
  endfunction

  // Trigger condition for one synchronised line (active low).
  function automatic logic trig(input logic level_mode, input logic prev, input logic cur);
    return level_mode ? ~cur : (prev & ~cur);
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din[i]};
      end
      assign dout[i] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] level_sel,
  output logic [N-1:0] evt
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= smp;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_evt
      assign evt[i] = trig(level_sel[i], prev_q[i], smp[i]);
    end
  endgenerate
endmodule

// File: rtl/ext_irq_src.sv
module ext_irq_src #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ack_clr,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] latch,
  output logic [N-1:0] flag
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      logic latch_q, flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          latch_q <= 1'b0;
          flag_q  <= 1'b0;
        end else begin
          // capture: set wins over acknowledge
          latch_q <= evt[i] | (latch_q & ~ack_clr[i]);
          // flag: set wins over clear; an unconsumed capture re-asserts it
          flag_q  <= evt[i] | latch_q | (flag_q & ~w1c[i]);
        end
      end
      assign latch[i] = latch_q;
      assign flag[i]  = flag_q;
    end
  endgenerate
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
#(
  parameter int          N       = 3,
  parameter logic [15:0] VEC_TOP = 16'h3FFA
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  input  logic         imask,
  output logic         req,
  output logic [N-1:0] win_oh,
  output logic [15:0]  vec
);
  logic [N-1:0] hit;
  assign hit = flag & en;

  always_comb begin
    win_oh = '0;
    vec    = VEC_TOP;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        vec       = vec_slot(VEC_TOP, i);
      end
    end
  end

  assign req = (|hit) & ~imask;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int          NSRC    = 3,
  parameter logic [15:0] VEC_TOP = 16'h3FFA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] line_n,
  input  logic            imask,
  input  logic            ack,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_req,
  output logic [15:0]     vec_addr
);
  logic [NSRC-1:0] en_q, sense_q;
  logic [NSRC-1:0] smp_w, evt_w, latch_w, flag_w, win_w, ack_clr_w, w1c_w;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
    end else if (reg_wr) begin
      if (sel == REG_ENABLE) en_q    <= reg_wdata;
      if (sel == REG_SENSE)  sense_q <= reg_wdata;
    end
  end

  assign w1c_w     = (reg_wr && sel == REG_FLAGS) ? reg_wdata : '0;
  assign ack_clr_w = ack ? win_w : '0;

  always_comb begin
    unique case (sel)
      REG_ENABLE: reg_rdata = en_q;
      REG_SENSE:  reg_rdata = sense_q;
      REG_FLAGS:  reg_rdata = flag_w;
      default:    reg_rdata = '0;
    endcase
  end

  ext_irq_sync #(.N(NSRC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_n), .dout(smp_w));

  ext_irq_detect #(.N(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(smp_w), .level_sel(sense_q), .evt(evt_w));

  ext_irq_src #(.N(NSRC)) u_src (
    .clk(clk), .rst_n(rst_n), .evt(evt_w), .ack_clr(ack_clr_w), .w1c(w1c_w),
    .latch(latch_w), .flag(flag_w));

  ext_irq_arb #(.N(NSRC), .VEC_TOP(VEC_TOP)) u_arb (
    .flag(flag_w), .en(en_q), .imask(imask), .req(irq_req), .win_oh(win_w),
    .vec(vec_addr));
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int          N       = 3,
  parameter logic [15:0] VEC_TOP = 16'h3FFA
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic         imask,
  input logic [N-1:0] evt,
  input logic [N-1:0] latch,
  input logic [N-1:0] flag,
  input logic [N-1:0] en,
  input logic [N-1:0] ack_clr,
  input logic [N-1:0] w1c,
  input logic [15:0]  vec
);
  // R4
  req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imask |-> !req);
  // R4
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((flag & en) != '0));
  // R5
  top_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && flag[0] && en[0]) |-> (vec == VEC_TOP));

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> (flag[i] && latch[i]));
      // R8
      capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch[i] && !ack_clr[i]) |=> latch[i]);
      // R7
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[i] && !w1c[i]) |=> flag[i]);
      // R6
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[i] && !evt[i] && !latch[i]) |=> !flag[i]);
      // R8
      capture_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch[i] |-> flag[i]);
    end
  endgenerate
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.N(NSRC), .VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(irq_req), .imask(imask), .evt(evt_w),
  .latch(latch_w), .flag(flag_w), .en(en_q), .ack_clr(ack_clr_w),
  .w1c(w1c_w), .vec(vec_addr));

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/10ps
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  line_n = 3'b111;
  logic        imask = 1'b0;
  logic        ack = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [2:0]  reg_wdata = 3'b000;
  logic [2:0]  reg_rdata;
  logic        irq_req;
  logic [15:0] vec_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string tag; int kind; logic [15:0] exp; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_n(line_n), .imask(imask), .ack(ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .vec_addr(vec_addr));

  // monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      item_t it;
      logic [15:0] got;
      wait (q.size() != 0);
      it = q.pop_front();
      case (it.kind)
        0:       got = {15'd0, irq_req};
        1:       got = vec_addr;
        default: got = {13'd0, reg_rdata};
      endcase
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push(string tag, int kind, logic [15:0] v);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = v;
    #0.1;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reg(string tag, logic [1:0] a, logic [2:0] v);
    reg_addr = a;
    push(tag, 2, {13'd0, v});
  endtask

  task automatic chk_req(string tag, logic v);
    push(tag, 0, {15'd0, v});
  endtask

  task automatic chk_vec(string tag, logic [15:0] v);
    push(tag, 1, v);
  endtask

  task automatic wr(logic [1:0] a, logic [2:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(posedge clk); @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic pulse_line(int i);
    line_n[i] = 1'b0;
    tick(2);
    line_n[i] = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_reg("R1 enable", 2'd0, 3'b000);
    chk_reg("R1 sense", 2'd1, 3'b000);
    chk_reg("R1 flags", 2'd2, 3'b000);
    chk_req("R1 req", 1'b0);

    // R9 register map
    wr(2'd0, 3'b111);
    chk_reg("R9 enable readback", 2'd0, 3'b111);
    wr(2'd3, 3'b111);
    chk_reg("R9 address 3 reads zero", 2'd3, 3'b000);
    chk_reg("R9 sense untouched", 2'd1, 3'b000);

    // R2 falling edge latency on source 0
    line_n[0] = 1'b0;
    tick(2);
    chk_reg("R2 not yet", 2'd2, 3'b000);
    tick(1);
    chk_reg("R2 flag set", 2'd2, 3'b001);
    chk_req("R4 req", 1'b1);
    chk_vec("R5 vector 0", 16'h3FFA);
    imask = 1'b1;
    chk_req("R4 masked", 1'b0);
    imask = 1'b0;
    // R7 ack keeps flag
    pulse_ack();
    chk_reg("R7 flag persists", 2'd2, 3'b001);
    chk_req("R7 req persists", 1'b1);
    // R6 / R2 clear with line held low, edge mode
    wr(2'd2, 3'b001);
    tick(2);
    chk_reg("R2 held low no retrigger", 2'd2, 3'b000);
    line_n[0] = 1'b1;
    tick(3);

    // R5 priority between 1 and 2
    line_n[2:1] = 2'b00;
    tick(3);
    chk_reg("R5 both flagged", 2'd2, 3'b110);
    chk_vec("R5 vector 1", 16'h3FF8);
    wr(2'd2, 3'b000);
    chk_reg("R6 zero write no effect", 2'd2, 3'b110);
    pulse_ack();
    wr(2'd2, 3'b010);
    chk_reg("R6 bit1 cleared", 2'd2, 3'b100);
    chk_vec("R5 vector 2", 16'h3FF4);
    pulse_ack();
    wr(2'd2, 3'b100);
    chk_reg("R6 all cleared", 2'd2, 3'b000);
    chk_req("R4 idle", 1'b0);
    line_n[2:1] = 2'b11;
    tick(3);

    // R8 one extra pulse during service
    pulse_line(1);
    tick(4);
    chk_reg("R8 first pulse", 2'd2, 3'b010);
    pulse_ack();
    pulse_line(1);
    tick(3);
    pulse_line(1);
    tick(4);
    wr(2'd2, 3'b010);
    chk_reg("R8 extra kept", 2'd2, 3'b010);
    chk_req("R8 request again", 1'b1);
    pulse_ack();
    wr(2'd2, 3'b010);
    chk_reg("R8 only one kept", 2'd2, 3'b000);

    // R3 level mode on source 2
    wr(2'd1, 3'b100);
    chk_reg("R9 sense readback", 2'd1, 3'b100);
    line_n[2] = 1'b0;
    tick(3);
    chk_reg("R3 level flag", 2'd2, 3'b100);
    wr(2'd0, 3'b011);
    chk_req("R4 disabled source", 1'b0);
    wr(2'd0, 3'b111);
    chk_req("R4 enabled source", 1'b1);
    pulse_ack();
    wr(2'd2, 3'b100);
    chk_reg("R3 clear ignored while low", 2'd2, 3'b100);
    line_n[2] = 1'b1;
    tick(4);
    pulse_ack();
    wr(2'd2, 3'b100);
    chk_reg("R3 cleared after release", 2'd2, 3'b000);
    wr(2'd1, 3'b000);

    // R10 trigger coincides with clear
    pulse_line(0);
    tick(4);
    pulse_ack();
    chk_reg("R10 setup flag", 2'd2, 3'b001);
    line_n[0] = 1'b0;
    tick(2);
    wr(2'd2, 3'b001);
    chk_reg("R10 set wins", 2'd2, 3'b001);
    pulse_ack();
    wr(2'd2, 3'b001);
    line_n[0] = 1'b1;
    tick(3);
    chk_reg("R10 final clear", 2'd2, 3'b000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule